// File: doc/BRIEF.md
# 64b/66b Transmit Block Encoder

This block sits between the reconciliation layer and the scrambler of a 10 Gb/s serial transmit path. On each clock it takes one 64-bit word as eight byte lanes. Each lane has its own control flag, and lane 0 is the earliest in time. The block decides which block format the lane pattern fits. It then builds the 66-bit block that the scrambler expects: a 2-bit sync header, an 8-bit block type for control blocks, and a payload of data bytes, 7-bit control codes and 4-bit ordered-set codes.

Bit 0 of the output vector is the first bit on the line. Every field (header, block type, data byte, control code, ordered-set code) is placed with its least significant bit at the lowest vector index. In transmission order, a field therefore appears bit-reversed within its own width. A lane pattern that fits no supported format becomes an all-error control block. The result is registered, so it appears one clock after the word is accepted, together with a valid strobe.

Lane i occupies `in_data[8i+7:8i]` and `in_ctrl[i]`. Control characters: idle 0x07, error 0xFE, start 0xFB, terminate 0xFD, sequence ordered set 0x9C, signal ordered set 0x5C.

Top module: `enc66_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` is 0 and `out_block` is all zeros after that edge.
- R2: `out_valid` rises one clock after a word is accepted with `in_valid` high. After a clock with `in_valid` low, `out_valid` is 0 and `out_block` keeps its previous value.
- R3: A word with all eight control flags clear gives `out_block[1:0]` = 2'b01 (bit 0 = 1 is sent first) and `out_block[65:2]` equal to `in_data`.
- R4: Any word with a control flag set gives a control block: `out_block[1:0]` = 2'b10 (bit 0 = 0 is sent first) and the block type in `out_block[9:2]`, LSB first.
- R5: Eight lanes holding only idle or error characters give type 0x1E. The 7-bit code of lane i sits at `out_block[10+7i +: 7]`, with idle mapped to 0x00 and error mapped to 0x1E.
- R6: A start character in lane 0 with data in lanes 1..7 gives type 0x78. Data lane i sits at `out_block[10+8(i-1) +: 8]`.
- R7: A terminate in lane k, with data in lanes below k and idle/error in lanes above k, gives type 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 or 0xFF for k = 0..7. Data lane j<k sits at `out_block[10+8j +: 8]`. The code of lane j>k sits at `out_block[10+8k+7(j-k-1) +: 7]`. All remaining upper bits are zero.
- R8: An ordered set in lane 0 and another in lane 4, with data in the other lanes, gives type 0x55. Lanes 1..3 sit at bits 10, 18 and 26. The lane-0 code (sequence 0x9C to 0x0, signal 0x5C to 0xF) sits at `[37:34]` and the lane-4 code at `[41:38]`. Lanes 5..7 sit at bits 42, 50 and 58.
- R9: An ordered set in lane 0 with data in lanes 1..3 and idle/error in lanes 4..7 gives type 0x4B: data at 10/18/26, O-code at `[37:34]`, codes of lanes 4..7 at 38/45/52/59. Idle/error in lanes 0..3 with an ordered set in lane 4 and data in lanes 5..7 gives type 0x2D: codes of lanes 0..3 at 10/17/24/31, O-code at `[41:38]`, data at 42/50/58.
- R10: Every other lane pattern gives type 0x1E with the error code 0x1E in all eight 7-bit slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_data | input | 64 | Eight byte lanes, lane 0 in bits 7:0 |
| in_ctrl | input | 8 | Per-lane control flag, lane i in bit i |
| out_valid | output | 1 | `out_block` holds a new block |
| out_block | output | 66 | Encoded block, bit 0 sent first |

## Verification
The assertions assume that `in_valid`, `in_data` and `in_ctrl` are driven to known values whenever reset is released. They also assume that a word is sampled only at the rising edge, so the registered block always reflects the word present at the previous edge. The bench changes its inputs only on falling edges and keeps `in_valid` at a defined level from the start of reset. Every pattern it sends, including the malformed ones, uses only bytes whose meaning the requirements fix.

// File: rtl/enc66_pkg.sv
// Package enc66_pkg
// Shared widths, character values, code values and the per-lane
// classification record for the 64b/66b transmit encoder.
// Assumes eight lanes of eight bits; all layout offsets derive from these.
package enc66_pkg;

    localparam int LANES    = 8;
    localparam int BYTE_W   = 8;
    localparam int C7_W     = 7;
    localparam int O4_W     = 4;
    localparam int HDR_W    = 2;
    localparam int TYPE_W   = 8;
    localparam int WORD_W   = LANES * BYTE_W;
    localparam int BLK_W    = HDR_W + WORD_W;
    localparam int TYPE_LSB = HDR_W;
    localparam int PAY_LSB  = HDR_W + TYPE_W;

    // Sync headers as vector values (bit 0 is sent first)
    localparam logic [HDR_W-1:0] HDR_DATA = 2'b01;
    localparam logic [HDR_W-1:0] HDR_CTRL = 2'b10;

    // Control characters arriving on the byte lanes
    localparam logic [BYTE_W-1:0] CH_IDLE  = 8'h07;
    localparam logic [BYTE_W-1:0] CH_ERR   = 8'hFE;
    localparam logic [BYTE_W-1:0] CH_START = 8'hFB;
    localparam logic [BYTE_W-1:0] CH_TERM  = 8'hFD;
    localparam logic [BYTE_W-1:0] CH_OSEQ  = 8'h9C;
    localparam logic [BYTE_W-1:0] CH_OSIG  = 8'h5C;

    // Line codes
    localparam logic [C7_W-1:0] C7_IDLE = 7'h00;
    localparam logic [C7_W-1:0] C7_ERR  = 7'h1E;
    localparam logic [O4_W-1:0] O4_SEQ  = 4'h0;
    localparam logic [O4_W-1:0] O4_SIG  = 4'hF;

    // Block types
    localparam logic [TYPE_W-1:0] BT_CTRL  = 8'h1E;
    localparam logic [TYPE_W-1:0] BT_S0    = 8'h78;
    localparam logic [TYPE_W-1:0] BT_O0O4  = 8'h55;
    localparam logic [TYPE_W-1:0] BT_O0C   = 8'h4B;
    localparam logic [TYPE_W-1:0] BT_CO4   = 8'h2D;

    // Per-lane classification record
    typedef struct packed {
        logic              is_data;
        logic              is_code;   // idle or error, has a 7-bit code
        logic              is_start;
        logic              is_term;
        logic              is_oset;   // sequence or signal ordered set
        logic [C7_W-1:0]   code7;
        logic [O4_W-1:0]   code4;
    } lane_class_t;

    // Block type of a terminate block by the lane that holds the terminate
    function automatic logic [TYPE_W-1:0] term_type(input int k);
        case (k)
            0:       return 8'h87;
            1:       return 8'h99;
            2:       return 8'hAA;
            3:       return 8'hB4;
            4:       return 8'hCC;
            5:       return 8'hD2;
            6:       return 8'hE1;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/enc66_lane_sort.sv
// Module enc66_lane_sort
// Classifies each byte lane independently: data, idle/error with its 7-bit
// line code, start, terminate, or ordered set with its 4-bit code.
// Assumes nothing about neighbouring lanes; unknown control bytes leave all
// class flags clear so that the packer falls back to an error block.
module enc66_lane_sort
    import enc66_pkg::*;
#(
    parameter int N_LANES = LANES
) (
    input  logic [N_LANES*BYTE_W-1:0]   lane_data,
    input  logic [N_LANES-1:0]          lane_ctrl,
    output lane_class_t [N_LANES-1:0]   lane_cls
);

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] b;
        logic              c;
        assign b = lane_data[g*BYTE_W +: BYTE_W];
        assign c = lane_ctrl[g];

        // Decode one lane's byte and flag into its class record
        always_comb begin
            lane_cls[g]          = '0;
            lane_cls[g].is_data  = !c;
            lane_cls[g].is_code  = c && ((b == CH_IDLE) || (b == CH_ERR));
            lane_cls[g].is_start = c && (b == CH_START);
            lane_cls[g].is_term  = c && (b == CH_TERM);
            lane_cls[g].is_oset  = c && ((b == CH_OSEQ) || (b == CH_OSIG));
            lane_cls[g].code7    = (c && (b == CH_ERR)) ? C7_ERR : C7_IDLE;
            lane_cls[g].code4    = (c && (b == CH_OSIG)) ? O4_SIG : O4_SEQ;
        end

        // R10: a lane never falls into two classes at once
        always_comb begin
            lane_onehot_chk: assert ($onehot0({lane_cls[g].is_data, lane_cls[g].is_code,
                                               lane_cls[g].is_start, lane_cls[g].is_term,
                                               lane_cls[g].is_oset}));
        end
    end

endmodule

// File: rtl/enc66_pack.sv
// Module enc66_pack
// Matches the eight lane classes against the supported block formats and
// assembles the 66-bit block, each field LSB at the lower index (sent first).
// Assumes lane classes from enc66_lane_sort; purely combinational.
module enc66_pack
    import enc66_pkg::*;
(
    input  lane_class_t [LANES-1:0] cls,
    input  logic [WORD_W-1:0]       data,
    output logic [BLK_W-1:0]        blk
);

    logic [LANES-1:0] dat_v, code_v;
    logic             all_data, all_code, start0;
    logic             os55, os4b, os2d;
    logic [LANES-1:0] term_ok;

    // Collect per-lane flags into vectors
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            dat_v[i]  = cls[i].is_data;
            code_v[i] = cls[i].is_code;
        end
    end

    // Recognise the whole-word formats
    always_comb begin
        all_data = &dat_v;
        all_code = &code_v;
        start0   = cls[0].is_start && (&dat_v[LANES-1:1]);
        os55     = cls[0].is_oset && (&dat_v[3:1]) && cls[4].is_oset && (&dat_v[7:5]);
        os4b     = cls[0].is_oset && (&dat_v[3:1]) && (&code_v[7:4]);
        os2d     = (&code_v[3:0]) && cls[4].is_oset && (&dat_v[7:5]);
    end

    // Recognise a terminate in each lane position
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            term_ok[k] = cls[k].is_term;
            for (int j = 0; j < LANES; j++) begin
                if (j < k) term_ok[k] = term_ok[k] && dat_v[j];
                if (j > k) term_ok[k] = term_ok[k] && code_v[j];
            end
        end
    end

    // Assemble the block for the matching format, else an error block
    always_comb begin
        blk = '0;
        if (all_data) begin
            blk[HDR_W-1:0]          = HDR_DATA;
            blk[BLK_W-1:HDR_W]      = data;
        end else begin
            blk[HDR_W-1:0]          = HDR_CTRL;
            if (all_code) begin
                blk[TYPE_LSB +: TYPE_W] = BT_CTRL;
                for (int i = 0; i < LANES; i++)
                    blk[PAY_LSB + C7_W*i +: C7_W] = cls[i].code7;
            end else if (start0) begin
                blk[TYPE_LSB +: TYPE_W] = BT_S0;
                for (int i = 1; i < LANES; i++)
                    blk[PAY_LSB + BYTE_W*(i-1) +: BYTE_W] = data[BYTE_W*i +: BYTE_W];
            end else if (|term_ok) begin
                for (int k = 0; k < LANES; k++) begin
                    if (term_ok[k]) begin
                        blk[TYPE_LSB +: TYPE_W] = term_type(k);
                        for (int j = 0; j < LANES; j++) begin
                            if (j < k)
                                blk[PAY_LSB + BYTE_W*j +: BYTE_W] = data[BYTE_W*j +: BYTE_W];
                            if (j > k)
                                blk[PAY_LSB + BYTE_W*k + C7_W*(j-k-1) +: C7_W] = cls[j].code7;
                        end
                    end
                end
            end else if (os55) begin
                blk[TYPE_LSB +: TYPE_W] = BT_O0O4;
                for (int i = 1; i < 4; i++)
                    blk[PAY_LSB + BYTE_W*(i-1) +: BYTE_W] = data[BYTE_W*i +: BYTE_W];
                blk[PAY_LSB + 24 +: O4_W] = cls[0].code4;
                blk[PAY_LSB + 28 +: O4_W] = cls[4].code4;
                for (int i = 5; i < LANES; i++)
                    blk[PAY_LSB + 32 + BYTE_W*(i-5) +: BYTE_W] = data[BYTE_W*i +: BYTE_W];
            end else if (os4b) begin
                blk[TYPE_LSB +: TYPE_W] = BT_O0C;
                for (int i = 1; i < 4; i++)
                    blk[PAY_LSB + BYTE_W*(i-1) +: BYTE_W] = data[BYTE_W*i +: BYTE_W];
                blk[PAY_LSB + 24 +: O4_W] = cls[0].code4;
                for (int i = 4; i < LANES; i++)
                    blk[PAY_LSB + 28 + C7_W*(i-4) +: C7_W] = cls[i].code7;
            end else if (os2d) begin
                blk[TYPE_LSB +: TYPE_W] = BT_CO4;
                for (int i = 0; i < 4; i++)
                    blk[PAY_LSB + C7_W*i +: C7_W] = cls[i].code7;
                blk[PAY_LSB + 28 +: O4_W] = cls[4].code4;
                for (int i = 5; i < LANES; i++)
                    blk[PAY_LSB + 32 + BYTE_W*(i-5) +: BYTE_W] = data[BYTE_W*i +: BYTE_W];
            end else begin
                blk[TYPE_LSB +: TYPE_W] = BT_CTRL;
                for (int i = 0; i < LANES; i++)
                    blk[PAY_LSB + C7_W*i +: C7_W] = C7_ERR;
            end
        end
    end

endmodule

// File: rtl/enc66_tx.sv
// Module enc66_tx
// 64b/66b transmit block encoder top: lane classification, block assembly
// and a single output register stage with a valid strobe.
// Assumes a synchronous active-low reset and one word per accepted clock.
module enc66_tx
    import enc66_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_data,
    input  logic [LANES-1:0]    in_ctrl,
    output logic                out_valid,
    output logic [BLK_W-1:0]    out_block
);

    lane_class_t [LANES-1:0] cls;
    logic [BLK_W-1:0]        blk_next;

    enc66_lane_sort #(.N_LANES(LANES)) u_sort (
        .lane_data (in_data),
        .lane_ctrl (in_ctrl),
        .lane_cls  (cls)
    );

    enc66_pack u_pack (
        .cls  (cls),
        .data (in_data),
        .blk  (blk_next)
    );

    // Register the assembled block when a word is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_block <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_block <= blk_next;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_block == '0));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_block)));

    // R3
    data_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ctrl == '0) |=>
            (out_block[HDR_W-1:0] == HDR_DATA && out_block[BLK_W-1:HDR_W] == $past(in_data)));

    // R4
    ctrl_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ctrl != '0) |=> (out_block[HDR_W-1:0] == HDR_CTRL));

endmodule

// File: tb/enc66_tx_tb.sv
`timescale 1ns/1ps
module enc66_tx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [7:0]  in_ctrl = '0;
    logic        out_valid;
    logic [65:0] out_block;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    enc66_tx u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .in_data (in_data), .in_ctrl (in_ctrl),
        .out_valid (out_valid), .out_block (out_block)
    );

    task automatic chk(input string req, input logic [65:0] got, input logic [65:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one word at a falling edge; results are sampled at the next one
    task automatic send(input logic [63:0] d, input logic [7:0] c);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_ctrl = c;
        @(negedge clk);
    endtask

    function automatic logic [65:0] ctl(input logic [7:0] t);
        logic [65:0] e = '0;
        e[1:0] = 2'b10; e[9:2] = t;
        return e;
    endfunction

    function automatic logic [65:0] err_blk();
        logic [65:0] e = ctl(8'h1E);
        for (int i = 0; i < 8; i++) e[10+7*i +: 7] = 7'h1E;
        return e;
    endfunction

    function automatic logic [7:0] tt(input int k);
        logic [7:0] t [8] = '{8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};
        return t[k];
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid", {65'b0, out_valid}, 66'b0);
        chk("R1 block", out_block, 66'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 no word", {65'b0, out_valid}, 66'b0);
    endtask

    task automatic t_data();
        send(64'h0123_4567_89AB_CDEF, 8'h00);
        chk("R2 valid", {65'b0, out_valid}, 66'd1);
        chk("R3 data a", out_block, {64'h0123_4567_89AB_CDEF, 2'b01});
        send(64'hFFFF_0000_FD07_FB5A, 8'h00);
        chk("R3 data b", out_block, {64'hFFFF_0000_FD07_FB5A, 2'b01});
    endtask

    task automatic t_idle();
        logic [65:0] e;
        send({8{8'h07}}, 8'hFF);
        chk("R5 all idle", out_block, ctl(8'h1E));
        e = ctl(8'h1E);
        e[10+7*2 +: 7] = 7'h1E; e[10+7*7 +: 7] = 7'h1E;
        send({8'hFE, 8'h07, 8'h07, 8'h07, 8'h07, 8'hFE, 8'h07, 8'h07}, 8'hFF);
        chk("R5 idle err mix", out_block, e);
        chk("R4 header", {64'b0, out_block[1:0]}, 66'd2);
    endtask

    task automatic t_start();
        send({56'h1122_3344_5566_77, 8'hFB}, 8'h01);
        chk("R6 start", out_block, {56'h1122_3344_5566_77, 8'h78, 2'b10});
    endtask

    task automatic t_term();
        for (int k = 0; k < 8; k++) begin
            logic [63:0] d; logic [7:0] c; logic [65:0] e;
            d = '0; c = '0; e = ctl(tt(k));
            for (int j = 0; j < 8; j++) begin
                if (j < k) begin
                    d[8*j +: 8] = 8'h10 + 8'(j);
                    e[10+8*j +: 8] = 8'h10 + 8'(j);
                end else if (j == k) begin
                    d[8*j +: 8] = 8'hFD; c[j] = 1'b1;
                end else begin
                    d[8*j +: 8] = (j % 2 == 1) ? 8'hFE : 8'h07; c[j] = 1'b1;
                    e[10+8*k+7*(j-k-1) +: 7] = (j % 2 == 1) ? 7'h1E : 7'h00;
                end
            end
            send(d, c);
            chk($sformatf("R7 term lane %0d", k), out_block, e);
        end
        // Terminate, error, idles: first sent bits 0,1 then 0x87 then 0x1E
        send({{6{8'h07}}, 8'hFE, 8'hFD}, 8'hFF);
        chk("R7 frame bits", {48'b0, out_block[16:0], 1'b0},
            {48'b0, 7'h1E, 8'h87, 2'b10, 1'b0});
        chk("R4 type lsb first", {65'b0, out_block[2]}, 66'd1);
    endtask

    task automatic t_oset();
        logic [65:0] e;
        send({8'h00, 8'h00, 8'h00, 8'h5C, 8'h00, 8'h00, 8'h00, 8'h9C}, 8'h11);
        e = ctl(8'h55); e[41:38] = 4'hF;
        chk("R8 seq then sig", out_block, e);
        send({8'hA7, 8'hA6, 8'hA5, 8'h9C, 8'hA3, 8'hA2, 8'hA1, 8'h5C}, 8'h11);
        e = ctl(8'h55);
        e[17:10] = 8'hA1; e[25:18] = 8'hA2; e[33:26] = 8'hA3;
        e[37:34] = 4'hF; e[41:38] = 4'h0;
        e[49:42] = 8'hA5; e[57:50] = 8'hA6; e[65:58] = 8'hA7;
        chk("R8 sig then seq", out_block, e);
        send({8'h07, 8'hFE, 8'h07, 8'hFE, 8'hB3, 8'hB2, 8'hB1, 8'h5C}, 8'hF1);
        e = ctl(8'h4B);
        e[17:10] = 8'hB1; e[25:18] = 8'hB2; e[33:26] = 8'hB3; e[37:34] = 4'hF;
        e[44:38] = 7'h1E; e[51:45] = 7'h00; e[58:52] = 7'h1E; e[65:59] = 7'h00;
        chk("R9 type 4B", out_block, e);
        send({8'hC7, 8'hC6, 8'hC5, 8'h5C, 8'hFE, 8'h07, 8'h07, 8'hFE}, 8'h1F);
        e = ctl(8'h2D);
        e[16:10] = 7'h1E; e[23:17] = 7'h00; e[30:24] = 7'h00; e[37:31] = 7'h1E;
        e[41:38] = 4'hF; e[49:42] = 8'hC5; e[57:50] = 8'hC6; e[65:58] = 8'hC7;
        chk("R9 type 2D", out_block, e);
    endtask

    task automatic t_error();
        send({8'h07, 8'h07, 8'h33, 8'h07, 8'h07, 8'hFD, 8'h11, 8'h22}, 8'hDC);
        chk("R10 data after term", out_block, err_blk());
        send({{4{8'h07}}, 8'h1C, {3{8'h07}}}, 8'hFF);
        chk("R10 unknown ctrl", out_block, err_blk());
        send({32'h0, 8'hFB, 24'h0}, 8'h08);
        chk("R10 start lane 3", out_block, err_blk());
        send({40'h0, 8'h9C, 16'h0}, 8'h04);
        chk("R10 oset lane 2", out_block, err_blk());
    endtask

    task automatic t_hold();
        logic [65:0] prev;
        send(64'hDEAD_BEEF_CAFE_F00D, 8'h00);
        prev = out_block;
        @(negedge clk);
        in_valid = 1'b0; in_data = 64'h5555_5555_5555_5555; in_ctrl = 8'hFF;
        @(negedge clk);
        chk("R2 valid drop", {65'b0, out_valid}, 66'b0);
        chk("R2 block hold", out_block, prev);
    endtask

    initial begin
        t_reset();
        t_data();
        t_idle();
        t_start();
        t_term();
        t_oset();
        t_error();
        t_hold();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule